// File: doc/BRIEF.md
# ADC Conversion Sequencer with Tagged Result Queue

This block is the digital control of an 8-channel, 10-bit successive-approximation converter. Software loads a list of up to sixteen conversion steps, each naming an input channel and a single-ended or differential mode, and then pulses `start`. The block runs the whole list without further attention. It divides the system clock down to a measurement tick. For each step it spends one tick on sampling and ten ticks on bit trials against an external comparator. It then places the finished code in a 16-entry result queue.

Each queue word carries the code together with the index of the step that produced it. A reader can therefore drain several results at once and still know which programmed step each one belongs to. A level watermark raises an interrupt. The queue reports overflow through a sticky flag. A separate asynchronous brownout input is synchronized and latched into a sticky status bit that also serves as an interrupt.

Top module: `adc_seq`

## Requirements
- R1: After reset, `busy`, `overrun`, `brownoutIrq` and `wmIrq` are 0, `fifoEmpty` is 1, `fifoLevel` is 0 and `fifoData` reads 0.
- R2: A run executes the steps with index 0 up to `stepLast` in ascending order. Step i is described by `stepTable[4i+3:4i]`, where bit 3 selects differential mode (1) or single-ended mode (0) and bits 2:0 select the channel. These fields appear on `diffMode` and `chanSel` and stay unchanged for the whole step.
- R3: Each step finds its code by trying bits from bit 9 down to bit 0, one per measurement tick, starting from the trial code 10'h200. A bit is kept when `cmpIn` is 1, meaning the input is at or above `trialCode`. For a monotonic comparator the stored code therefore equals the input level.
- R4: A queue word holds the step index in bits 15:12, zeros in bits 11:10 and the 10-bit code in bits 9:0.
- R5: A measurement tick occurs every `clkDiv`+1 system cycles. Each step takes 11 ticks. `busy` is therefore high for exactly (`stepLast`+1)·11·(`clkDiv`+1) cycles after the start pulse.
- R6: The queue returns words in the order they were written. `fifoLevel` counts the stored words, up to 16. `fifoData` always shows the oldest word, and `popEn` removes that word. A pop while the queue is empty has no effect.
- R7: A result that arrives while 16 words are already stored is discarded and sets `overrun`. The stored words and the level stay unchanged.
- R8: `wmIrq` is 1 exactly when `watermark` is non-zero and `fifoLevel` ≥ `watermark`.
- R9: `brownoutAsync` passes through two synchronizer flops. A high level on the input sets `brownoutIrq` at the third rising edge. The bit stays set after the input falls. `statusClr` clears it only while the synchronized input is low.
- R10: A `start` pulse while `busy` is high is ignored. The run in progress keeps its length and produces no extra results.
- R11: `overrun` is sticky and is cleared by `statusClr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins a run of the step list when idle |
| clkDiv | input | 8 | Measurement tick period minus one, in system cycles |
| stepLast | input | 4 | Index of the last step to run |
| stepTable | input | 64 | Sixteen 4-bit step descriptors |
| cmpIn | input | 1 | Comparator: 1 when the input is at or above `trialCode` |
| chanSel | output | 3 | Channel of the current step |
| diffMode | output | 1 | Differential mode of the current step |
| trialCode | output | 10 | Code presented to the converter's DAC |
| busy | output | 1 | A run is in progress |
| popEn | input | 1 | Remove the oldest queue word |
| watermark | input | 5 | Level at which `wmIrq` asserts; 0 disables it |
| statusClr | input | 1 | Clears the sticky overrun and brownout bits |
| fifoData | output | 16 | Oldest queue word (tag, zero pad, code) |
| fifoEmpty | output | 1 | Queue holds no word |
| fifoLevel | output | 5 | Number of stored words |
| wmIrq | output | 1 | Level interrupt |
| overrun | output | 1 | Sticky: a result was dropped |
| brownoutAsync | input | 1 | Asynchronous brownout comparator output |
| brownoutIrq | output | 1 | Sticky brownout status and interrupt |

## Verification
The bench aims at the codes at both ends of the range. A design that decides bit 0 off by one, or that clears the kept bit, would turn 0 or 1023 into a neighbouring value. It measures how long a run takes for several divider values, which exposes a divider that counts `clkDiv` instead of `clkDiv`+1 or a step that takes one tick too many or too few. It fills the queue exactly to 16 words and then pushes once more; a wrong full test would either overwrite the oldest word or report overflow one word early. It also times the brownout path edge by edge and checks that a clear loses to a set that is still arriving, since a missing synchronizer stage or a clear that takes priority both show up as a one-cycle or sticky-bit mismatch.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int RES_W  = 10;
  localparam int TAG_W  = 4;
  localparam int CH_W   = 3;
  localparam int ENT_W  = CH_W + 1;
  localparam int STEP_N = 1 << TAG_W;
  localparam int WORD_W = 16;
  localparam int PAD_W  = WORD_W - TAG_W - RES_W;
  localparam int BIT_W  = $clog2(RES_W);

  typedef struct packed {
    logic             push;
    logic [TAG_W-1:0] tag;
    logic [RES_W-1:0] result;
  } seqStrobe_t;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_SAMPLE,
    SEQ_TRIAL
  } seqState_e;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [DIV_W-1:0]        clkDiv,
  input  logic [TAG_W-1:0]        stepLast,
  input  logic [STEP_N*ENT_W-1:0] stepTable,
  input  logic                    cmpIn,
  output logic [CH_W-1:0]         chanSel,
  output logic                    diffMode,
  output logic [RES_W-1:0]        trialCode,
  output logic                    busy,
  output seqStrobe_t              strobe
);
  seqState_e        state;
  logic [DIV_W-1:0] divCnt;
  logic [TAG_W-1:0] stepIdx;
  logic [BIT_W-1:0] bitIdx;
  logic             tick;
  logic             lastBit;
  logic [RES_W-1:0] decided;
  logic [ENT_W-1:0] entry;

  assign busy    = (state != SEQ_IDLE);
  assign tick    = busy && (divCnt == clkDiv);
  assign lastBit = (bitIdx == '0);
  assign entry   = stepTable[stepIdx*ENT_W +: ENT_W];
  assign chanSel = entry[CH_W-1:0];
  assign diffMode = entry[ENT_W-1];

  // Keep the trial bit when the input is at or above the trial level.
  always_comb begin
    decided = cmpIn ? trialCode : (trialCode & ~(RES_W'(1) << bitIdx));
  end

  always_comb begin
    strobe.push   = tick && (state == SEQ_TRIAL) && lastBit;
    strobe.tag    = stepIdx;
    strobe.result = decided;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= SEQ_IDLE;
      divCnt    <= '0;
      stepIdx   <= '0;
      bitIdx    <= '0;
      trialCode <= '0;
    end else begin
      divCnt <= (!busy || tick) ? '0 : divCnt + 1'b1;
      case (state)
        SEQ_IDLE: begin
          if (start) begin
            state     <= SEQ_SAMPLE;
            stepIdx   <= '0;
            trialCode <= '0;
          end
        end
        SEQ_SAMPLE: begin
          if (tick) begin
            trialCode <= RES_W'(1) << (RES_W - 1);
            bitIdx    <= BIT_W'(RES_W - 1);
            state     <= SEQ_TRIAL;
          end
        end
        SEQ_TRIAL: begin
          if (tick) begin
            if (lastBit) begin
              trialCode <= decided;
              if (stepIdx == stepLast) begin
                state <= SEQ_IDLE;
              end else begin
                stepIdx <= stepIdx + 1'b1;
                state   <= SEQ_SAMPLE;
              end
            end else begin
              trialCode <= decided | (RES_W'(1) << (bitIdx - 1'b1));
              bitIdx    <= bitIdx - 1'b1;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              popEn,
  input  logic [LVL_W-1:0]  watermark,
  input  logic              statusClr,
  input  logic              brownoutAsync,
  output logic [WORD_W-1:0] fifoData,
  output logic              fifoEmpty,
  output logic [LVL_W-1:0]  fifoLevel,
  output logic              wmIrq,
  output logic              overrun,
  output logic              brownoutIrq
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic              full;
  logic              pushOk;
  logic              popOk;
  logic [1:0]        boSync;
  logic [WORD_W-1:0] pushWord;

  assign full      = (fifoLevel == LVL_W'(DEPTH));
  assign fifoEmpty = (fifoLevel == '0);
  assign pushOk    = strobe.push && !full;
  assign popOk     = popEn && !fifoEmpty;
  assign pushWord  = {strobe.tag, {PAD_W{1'b0}}, strobe.result};
  assign fifoData  = fifoEmpty ? '0 : mem[rdPtr];
  assign wmIrq     = (watermark != '0) && (fifoLevel >= watermark);

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr       <= '0;
      rdPtr       <= '0;
      fifoLevel   <= '0;
      overrun     <= 1'b0;
      boSync      <= '0;
      brownoutIrq <= 1'b0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (popOk)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      fifoLevel   <= fifoLevel + LVL_W'(pushOk) - LVL_W'(popOk);
      overrun     <= (strobe.push && full) || (overrun && !statusClr);
      boSync      <= {boSync[0], brownoutAsync};
      brownoutIrq <= boSync[1] || (brownoutIrq && !statusClr);
    end
  end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [DIV_W-1:0]              clkDiv,
  input  logic [TAG_W-1:0]              stepLast,
  input  logic [STEP_N*ENT_W-1:0]       stepTable,
  input  logic                          cmpIn,
  output logic [CH_W-1:0]               chanSel,
  output logic                          diffMode,
  output logic [RES_W-1:0]              trialCode,
  output logic                          busy,
  input  logic                          popEn,
  input  logic [$clog2(DEPTH+1)-1:0]    watermark,
  input  logic                          statusClr,
  output logic [WORD_W-1:0]             fifoData,
  output logic                          fifoEmpty,
  output logic [$clog2(DEPTH+1)-1:0]    fifoLevel,
  output logic                          wmIrq,
  output logic                          overrun,
  input  logic                          brownoutAsync,
  output logic                          brownoutIrq
);
  seqStrobe_t strobe;

  adc_seq_ctrl #(.DIV_W(DIV_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .clkDiv    (clkDiv),
    .stepLast  (stepLast),
    .stepTable (stepTable),
    .cmpIn     (cmpIn),
    .chanSel   (chanSel),
    .diffMode  (diffMode),
    .trialCode (trialCode),
    .busy      (busy),
    .strobe    (strobe)
  );

  adc_seq_dp #(.DEPTH(DEPTH)) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .popEn         (popEn),
    .watermark     (watermark),
    .statusClr     (statusClr),
    .brownoutAsync (brownoutAsync),
    .fifoData      (fifoData),
    .fifoEmpty     (fifoEmpty),
    .fifoLevel     (fifoLevel),
    .wmIrq         (wmIrq),
    .overrun       (overrun),
    .brownoutIrq   (brownoutIrq)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             push,
  input logic [CH_W-1:0]  chanSel,
  input logic             diffMode,
  input logic             popEn,
  input logic             statusClr,
  input logic [LVL_W-1:0] fifoLevel,
  input logic             fifoEmpty,
  input logic             overrun,
  input logic             brownoutIrq
);
  AST_STEP_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    busy && !push |=> $stable({diffMode, chanSel})); // R2

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LVL_W'(DEPTH)); // R6

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmpty && popEn && !push |=> fifoEmpty); // R6

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    push && (fifoLevel == LVL_W'(DEPTH)) |=> overrun); // R7

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (fifoLevel == LVL_W'(DEPTH)) && !popEn |=> (fifoLevel == LVL_W'(DEPTH))); // R7

  AST_BROWNOUT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    brownoutIrq && !statusClr |=> brownoutIrq); // R9

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !statusClr |=> overrun); // R11
endmodule

bind adc_seq adc_seq_chk #(.DEPTH(DEPTH)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busy        (busy),
  .push        (strobe.push),
  .chanSel     (chanSel),
  .diffMode    (diffMode),
  .popEn       (popEn),
  .statusClr   (statusClr),
  .fifoLevel   (fifoLevel),
  .fifoEmpty   (fifoEmpty),
  .overrun     (overrun),
  .brownoutIrq (brownoutIrq)
);

// File: tb/test_adc_seq.sv
module test_adc_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  clkDiv = '0;
  logic [3:0]  stepLast = '0;
  logic [63:0] stepTable = '0;
  logic        cmpIn;
  logic [2:0]  chanSel;
  logic        diffMode;
  logic [9:0]  trialCode;
  logic        busy;
  logic        popEn = 1'b0;
  logic [4:0]  watermark = '0;
  logic        statusClr = 1'b0;
  logic [15:0] fifoData;
  logic        fifoEmpty;
  logic [4:0]  fifoLevel;
  logic        wmIrq;
  logic        overrun;
  logic        brownoutAsync = 1'b0;
  logic        brownoutIrq;

  int  tests = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  adc_seq i_adc_seq (
    .clk(clk), .rstN(rstN), .start(start), .clkDiv(clkDiv), .stepLast(stepLast),
    .stepTable(stepTable), .cmpIn(cmpIn), .chanSel(chanSel), .diffMode(diffMode),
    .trialCode(trialCode), .busy(busy), .popEn(popEn), .watermark(watermark),
    .statusClr(statusClr), .fifoData(fifoData), .fifoEmpty(fifoEmpty),
    .fifoLevel(fifoLevel), .wmIrq(wmIrq), .overrun(overrun),
    .brownoutAsync(brownoutAsync), .brownoutIrq(brownoutIrq)
  );

  // Analog model: input level for each step descriptor.
  function automatic logic [9:0] vinOf(input logic [3:0] ent);
    int ch;
    ch = int'(ent[2:0]);
    if (!ent[3]) begin
      if (ch == 0) return 10'd0;
      if (ch == 7) return 10'd1023;
      return 10'(ch * 131 + 11);
    end
    return 10'(1023 - ch * 140);
  endfunction

  assign cmpIn = (vinOf({diffMode, chanSel}) >= trialCode);

  // {stepLast, clkDiv, stepTable}
  localparam logic [75:0] VECS [4] = '{
    {4'd3,  8'd0, 64'h0000_0000_0000_F870},
    {4'd7,  8'd2, 64'h0000_0000_9AC4_5E31},
    {4'd0,  8'd5, 64'h0000_0000_0000_000B},
    {4'd11, 8'd1, 64'h0000_BDA6_2C85_1E79}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runSeq(input bit restartMid, output int cycles);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cycles = 0;
    while (busy) begin
      cycles++;
      if (restartMid && cycles == 10) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic popOne;
    popEn = 1'b1;
    @(negedge clk) popEn = 1'b0;
  endtask

  task automatic finishRun;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    int cyc;
    logic [15:0] expWord;
    watermark = 5'd1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!busy, "R1 busy", busy, 0);
    chk(fifoEmpty && fifoLevel == 0, "R1 level", fifoLevel, 0);
    chk(!overrun && !brownoutIrq, "R1 flags", {overrun, brownoutIrq}, 0);
    chk(!wmIrq, "R1 wmIrq", wmIrq, 0);
    chk(fifoData == 16'h0, "R1 data", fifoData, 0);
    watermark = 5'd0;

    // Vector table: R2 R3 R4 R5 R6
    for (int v = 0; v < 4; v++) begin
      stepLast  = VECS[v][75:72];
      clkDiv    = VECS[v][71:64];
      stepTable = VECS[v][63:0];
      runSeq(1'b0, cyc);
      chk(cyc == (int'(stepLast) + 1) * 11 * (int'(clkDiv) + 1), "R5 run length",
          cyc, (int'(stepLast) + 1) * 11 * (int'(clkDiv) + 1));
      chk(fifoLevel == 5'(int'(stepLast) + 1), "R6 level", fifoLevel, int'(stepLast) + 1);
      for (int i = 0; i <= int'(stepLast); i++) begin
        expWord = {4'(i), 2'b00, vinOf(stepTable[i*4 +: 4])};
        chk(fifoData == expWord, "R2 R3 R4 word", fifoData, expWord);
        popOne();
      end
      chk(fifoEmpty, "R6 drained", fifoLevel, 0);
    end

    // R10 start while busy
    stepLast = 4'd1; clkDiv = 8'd1; stepTable = 64'h0000_0000_0000_00F0;
    runSeq(1'b1, cyc);
    repeat (3) @(negedge clk);
    chk(cyc == 44, "R10 run length", cyc, 44);
    chk(!busy && fifoLevel == 2, "R10 results", fifoLevel, 2);
    popOne(); popOne();

    // R7 R8 fill exactly, then overflow
    stepLast = 4'd15; clkDiv = 8'd0; stepTable = 64'h3C5A_BDA6_2C85_1E79;
    runSeq(1'b0, cyc);
    chk(fifoLevel == 16 && !overrun, "R7 full no overrun", {overrun, fifoLevel}, 16);
    watermark = 5'd16; #1;
    chk(wmIrq, "R8 at watermark", wmIrq, 1);
    watermark = 5'd17; #1;
    chk(!wmIrq, "R8 above level", wmIrq, 0);
    watermark = 5'd0; #1;
    chk(!wmIrq, "R8 disabled", wmIrq, 0);
    watermark = 5'd15; #1;
    chk(wmIrq, "R8 below level", wmIrq, 1);
    stepLast = 4'd0;
    runSeq(1'b0, cyc);
    chk(overrun, "R7 overrun set", overrun, 1);
    chk(fifoLevel == 16, "R7 level held", fifoLevel, 16);
    expWord = {4'd0, 2'b00, vinOf(stepTable[3:0])};
    chk(fifoData == expWord, "R7 head kept", fifoData, expWord);
    @(negedge clk) statusClr = 1'b1;
    @(negedge clk) statusClr = 1'b0;
    chk(!overrun, "R11 overrun cleared", overrun, 0);
    for (int i = 0; i < 16; i++) begin
      expWord = {4'(i), 2'b00, vinOf(stepTable[i*4 +: 4])};
      chk(fifoData == expWord, "R6 R7 order", fifoData, expWord);
      popOne();
    end
    popOne();
    chk(fifoEmpty && fifoLevel == 0, "R6 empty pop", fifoLevel, 0);
    chk(!wmIrq, "R8 empty", wmIrq, 0);

    // R9 brownout timing and stickiness
    brownoutAsync = 1'b1;
    @(negedge clk);
    chk(!brownoutIrq, "R9 edge1", brownoutIrq, 0);
    @(negedge clk);
    chk(!brownoutIrq, "R9 edge2", brownoutIrq, 0);
    @(negedge clk);
    chk(brownoutIrq, "R9 edge3", brownoutIrq, 1);
    statusClr = 1'b1;
    @(negedge clk) statusClr = 1'b0;
    chk(brownoutIrq, "R9 set wins", brownoutIrq, 1);
    brownoutAsync = 1'b0;
    repeat (4) @(negedge clk);
    chk(brownoutIrq, "R9 sticky", brownoutIrq, 1);
    statusClr = 1'b1;
    @(negedge clk) statusClr = 1'b0;
    chk(!brownoutIrq, "R9 cleared", brownoutIrq, 0);

    finishRun();
  end
endmodule